// File: doc/BRIEF.md
# Fused Range-Azimuth Convolution Pipeline

This block filters a radar image stream in both dimensions at once. Range samples of consecutive pulse returns enter one per accepted cycle, in raster order (all range bins of one pulse, then the next pulse). A single shift chain holds enough history to reach back across several pulses. Coefficient taps are placed in groups: each group covers adjacent range bins of one pulse, and successive groups sit exactly one pulse length apart. The weighted sum of all taps is therefore a two-dimensional convolution, produced without a separate range filter, transpose memory and azimuth filter.

The designer picks the pulse length `N`, the range kernel length `R` (with `R <= N`), the azimuth kernel length `A`, the sample width `W`, the coefficient width `CW` and the coefficient set `COEFS` at elaboration time. Once the chain holds a full window, every accepted sample yields one result after a fixed number of cycles. Samples at the start of a pulse are combined with the tail of the previous pulse: no edge masking is applied.

Top module: `fused_sar_fir`

## Requirements
- R1: A synchronous active-low reset clears the history and the result pipeline. `out_valid` is low in every cycle during reset and in the first cycle after reset. A reset in the middle of a stream restarts the fill count from zero.
- R2: `out_valid` stays low until the accepted sample that makes the count since reset reach `LEN = A*N - (N-R)`. That sample and every accepted sample after it produce a result.
- R3: For the k-th accepted sample x[k], the result equals the sum over i in [0,A) and j in [0,R) of c(i,j)*x[k - i*N - j]. Here c(i,j) is the signed `CW`-bit field `COEFS[(i*R+j)*CW +: CW]`.
- R4: A sample accepted at a rising edge produces its result on `out_data`, with `out_valid` high, after exactly `clog2(A*R)+1` further rising edges. Across the edges that stand between, that is `clog2(A*R)+2` edges counted from the accepting edge.
- R5: The history advances only on cycles with `in_valid` high, and an idle cycle leaves it unchanged. Idle cycles produce no result and do not change the result that later samples produce.
- R6: `out_data` is `W+CW+clog2(A*R)` bits wide and signed. It holds the exact sum for any full-scale inputs and coefficients, without wrap-around.
- R7: Exactly one result is produced for each accepted sample after fill, and no result is produced at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | W | Signed two's-complement range sample |
| out_valid | output | 1 | Qualifies `out_data` in this cycle |
| out_data | output | W+CW+clog2(A*R) | Signed filtered sample |

## Verification
The hardest case to reach is a stall that lands while a sample sits in the stretch of the chain between two tap groups. Another is a stall just as the fill count crosses `LEN`. In both, a wrong advance would shift the pulse-to-pulse alignment by one bin, and only some later outputs would show it. The stimulus runs long stretches with in_valid dropped at random, at about half the cycles, both during fill and in steady state. It also resets in the middle of a stream and fills again. Every cycle is then compared against a history-based convolution model, so a single misplaced sample shows up as a wrong value or a wrongly timed valid.

// File: rtl/sar_fir_pkg.sv
// Shared helpers for the fused range-azimuth filter.
// Assumes R <= N so that tap groups never overlap.
package sar_fir_pkg;

    // Number of sample registers needed to reach the oldest tap.
    function automatic int chain_len(input int a, input int n, input int r);
        return a * n - (n - r);
    endfunction

    // Chain position of the tap for azimuth index i and range index j.
    function automatic int tap_pos(input int i, input int j, input int n);
        return i * n + j;
    endfunction

endpackage

// File: rtl/sar_sample_chain.sv
// Sample history shift chain.
// Holds the last LEN accepted samples. Stage 0 is the newest. It exposes only
// the A*R positions that carry a coefficient: groups of R adjacent stages,
// with one group every N stages. Shifts only when shift_en is high.
module sar_sample_chain
    import sar_fir_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 4,
    parameter int R = 2,
    parameter int A = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [W-1:0]     din,
    output logic [A*R*W-1:0] tap_bus
);
    localparam int LEN = chain_len(A, N, R);

    logic [W-1:0] stage [LEN];

    // Advance the history by one sample on each accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LEN; k++) stage[k] <= '0;
        end else if (shift_en) begin
            stage[0] <= din;
            for (int k = 1; k < LEN; k++) stage[k] <= stage[k-1];
        end
    end

    // Route each coefficient position of the chain to its slot on the tap bus.
    for (genvar gi = 0; gi < A; gi++) begin : g_grp
        for (genvar gj = 0; gj < R; gj++) begin : g_tap
            assign tap_bus[(gi*R+gj)*W +: W] = stage[tap_pos(gi, gj, N)];
        end
    end

endmodule

// File: rtl/sar_tap_mult.sv
// Constant-coefficient multipliers, one per tap, with a registered output.
// Tap k is multiplied by the signed field COEFS[k*CW +: CW]. The full
// W+CW-bit product is kept, so no rounding or overflow occurs here.
module sar_tap_mult #(
    parameter int W  = 8,
    parameter int CW = 8,
    parameter int NT = 6,
    parameter logic [NT*CW-1:0] COEFS = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NT*W-1:0]       tap_bus,
    output logic [NT*(W+CW)-1:0]  prod_bus
);
    localparam int PW = W + CW;

    for (genvar k = 0; k < NT; k++) begin : g_mul
        localparam logic signed [CW-1:0] COEF = COEFS[k*CW +: CW];
        logic signed [W-1:0]  x;
        logic signed [PW-1:0] p_q;

        assign x = tap_bus[k*W +: W];

        // Register the weighted sample of this tap.
        always_ff @(posedge clk) begin
            if (!rst_n) p_q <= '0;
            else        p_q <= x * COEF;
        end

        assign prod_bus[k*PW +: PW] = p_q;
    end

endmodule

// File: rtl/sar_adder_tree.sv
// Registered binary adder tree.
// Sums NL signed IW-bit leaves into one signed OW-bit result. The leaves are
// padded with zeros to a power of two, P = 2**clog2(NL). The nodes are kept
// in heap order: node n adds children 2n+1 and 2n+2, and the leaves take
// heap slots P-1 .. 2P-2. Each tree level is one register stage, so the
// latency is clog2(NL) cycles. Assumes OW >= IW + clog2(NL).
module sar_adder_tree #(
    parameter int IW = 16,
    parameter int NL = 6,
    parameter int OW = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NL*IW-1:0]     leaves,
    output logic signed [OW-1:0] sum
);
    localparam int D = $clog2(NL);
    localparam int P = 1 << D;

    logic signed [OW-1:0] kids [2*P-1];

    if (D == 0) begin : g_flat
        logic signed [IW-1:0] only;
        assign only = leaves[IW-1:0];
        // Single leaf: sign-extend it, no register stage.
        always_comb begin
            kids[0] = OW'(only);
        end
        assign sum = kids[0];
    end else begin : g_tree
        logic signed [OW-1:0] node [P-1];

        // Gather internal nodes and sign-extended, zero-padded leaves into heap order.
        always_comb begin
            logic signed [IW-1:0] t;
            for (int n = 0; n < P - 1; n++) kids[n] = node[n];
            for (int k = 0; k < P; k++) begin
                if (k < NL) begin
                    t = leaves[k*IW +: IW];
                    kids[P-1+k] = OW'(t);
                end else begin
                    t = '0;
                    kids[P-1+k] = '0;
                end
            end
        end

        // Each internal node registers the sum of its two children.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int n = 0; n < P - 1; n++) node[n] <= '0;
            end else begin
                for (int n = 0; n < P - 1; n++) node[n] <= kids[2*n+1] + kids[2*n+2];
            end
        end

        assign sum = node[0];
    end

endmodule

// File: rtl/sar_fill_track.sv
// Result-valid tracker.
// Counts accepted samples since reset, saturating at LEN. It marks an
// accepted sample as producing a result once the chain holds a full window,
// then delays that mark by LAT cycles to line it up with the data path.
module sar_fill_track #(
    parameter int LEN = 10,
    parameter int LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic out_valid
);
    localparam int CNT_W = $clog2(LEN + 1);

    logic [CNT_W-1:0] cnt;
    logic [LAT-1:0]   vpipe;
    logic             full_hit;

    assign full_hit = in_valid && (cnt >= CNT_W'(LEN - 1));

    // Count accepted samples until the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (in_valid && cnt != CNT_W'(LEN)) cnt <= cnt + 1'b1;
    end

    // Carry the result-valid mark along with the data pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[LAT-2:0], full_hit};
    end

    assign out_valid = vpipe[LAT-1];

endmodule

// File: rtl/fused_sar_fir.sv
// Fused range-azimuth FIR filter, top level.
// One shift chain feeds A*R constant-coefficient taps, placed in A groups of
// R adjacent taps with one pulse (N samples) between groups. The registered
// products are summed by a registered adder tree. Latency from the accepting
// edge to the result is clog2(A*R)+2 edges. Assumes R <= N. Samples near a
// pulse boundary are mixed with the previous pulse: no masking is applied.
module fused_sar_fir
    import sar_fir_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 8,
    parameter int N  = 4,
    parameter int R  = 2,
    parameter int A  = 3,
    parameter logic [A*R*CW-1:0] COEFS = 48'hFF40F97F8003
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    in_valid,
    input  logic signed [W-1:0]                     in_data,
    output logic                                    out_valid,
    output logic signed [W+CW+$clog2(A*R)-1:0]      out_data
);
    localparam int NT  = A * R;
    localparam int D   = $clog2(NT);
    localparam int LEN = chain_len(A, N, R);
    localparam int PW  = W + CW;
    localparam int OW  = PW + D;
    localparam int LAT = D + 2;

    logic [NT*W-1:0]  tap_bus;
    logic [NT*PW-1:0] prod_bus;

    sar_sample_chain #(.W(W), .N(N), .R(R), .A(A)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (in_data),
        .tap_bus  (tap_bus)
    );

    sar_tap_mult #(.W(W), .CW(CW), .NT(NT), .COEFS(COEFS)) u_mult (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_bus  (tap_bus),
        .prod_bus (prod_bus)
    );

    sar_adder_tree #(.IW(PW), .NL(NT), .OW(OW)) u_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .leaves (prod_bus),
        .sum    (out_data)
    );

    sar_fill_track #(.LEN(LEN), .LAT(LAT)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/fused_sar_fir_chk.sv
// Protocol checker for fused_sar_fir, attached with bind.
// Keeps its own fill count and expected-valid delay line, and watches the
// tap positions of the history chain.
module fused_sar_fir_chk
    import sar_fir_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 4,
    parameter int R = 2,
    parameter int A = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [W-1:0]     in_data,
    input logic             out_valid,
    input logic [A*R*W-1:0] tap_bus
);
    localparam int LEN   = chain_len(A, N, R);
    localparam int LAT   = $clog2(A * R) + 2;
    localparam int SEEN_W = $clog2(LEN + 1);

    logic [SEEN_W-1:0] seen;
    logic [LAT-1:0]    exp_v;

    // Independent count of accepted samples, saturating at a full window.
    always_ff @(posedge clk) begin
        if (!rst_n)                              seen <= '0;
        else if (in_valid && seen != SEEN_W'(LEN)) seen <= seen + 1'b1;
    end

    // Expected result-valid timeline derived from the port stream.
    always_ff @(posedge clk) begin
        if (!rst_n) exp_v <= '0;
        else        exp_v <= {exp_v[LAT-2:0], in_valid && (seen >= SEEN_W'(LEN - 1))};
    end

    // R1: first cycle out of reset carries no result.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R2: a result only appears once a full window has been accepted.
    p_fill_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen == SEEN_W'(LEN)));

    // R4 / R7: results appear exactly at the fixed latency, one per eligible sample.
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == exp_v[LAT-1]);

    // R5: an idle cycle leaves the history untouched.
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(tap_bus));

    // R5: an accepted sample lands in the newest chain position.
    p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (tap_bus[W-1:0] == $past(in_data)));

endmodule

bind fused_sar_fir fused_sar_fir_chk #(.W(W), .N(N), .R(R), .A(A)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .tap_bus   (tap_bus)
);

// File: tb/fused_sar_fir_tb.sv
// Self-checking bench: history-based 2D convolution model compared every cycle.
module fused_sar_fir_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int CW = 8;
    localparam int N  = 4;
    localparam int R  = 2;
    localparam int A  = 3;
    localparam int LEN  = A * N - (N - R);
    localparam int LAT  = $clog2(A * R) + 2;
    localparam int ACCW = W + CW + $clog2(A * R);
    localparam int WATCHDOG = 20000;
    // c(i,j) at index i*R+j: 3, -128, 127, -7, 64, -1
    localparam logic [A*R*CW-1:0] COEFS = {8'hFF, 8'h40, 8'hF9, 8'h7F, 8'h80, 8'h03};
    localparam int CF [A*R] = '{3, -128, 127, -7, 64, -1};

    typedef struct { longint val; int due; } exp_t;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic signed [W-1:0]    in_data = '0;
    logic                   out_valid;
    logic signed [ACCW-1:0] out_data;

    int     cyc = 0;
    int     total = 0;
    int     fails = 0;
    int     pushed = 0;
    int     dropped = 0;
    int     got = 0;
    bit     done = 1'b0;
    string  idle_tag = "R1";
    exp_t   pend [$];
    int     hist [$];

    fused_sar_fir #(.W(W), .CW(CW), .N(N), .R(R), .A(A), .COEFS(COEFS)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Compare the outputs after the latest edge with the model.
    task automatic compare();
        if (pend.size() > 0 && pend[0].due == cyc) begin
            chk(out_valid === 1'b1, "R4", longint'(out_valid), 1);
            chk(longint'(out_data) == pend[0].val, "R3", longint'(out_data), pend[0].val);
            void'(pend.pop_front());
            got++;
        end else begin
            chk(out_valid === 1'b0, idle_tag, longint'(out_valid), 0);
        end
    endtask

    // One cycle: check, then drive the next input and update the model.
    task automatic step(input bit v, input int d);
        @(negedge clk);
        compare();
        in_valid = v;
        in_data  = W'(d);
        if (v) begin
            hist.push_back(d);
            if (hist.size() >= LEN) begin
                exp_t e;
                longint s = 0;
                int last = hist.size() - 1;
                for (int i = 0; i < A; i++)
                    for (int j = 0; j < R; j++)
                        s += longint'(CF[i*R+j]) * longint'(hist[last - (i*N + j)]);
                e.val = s;
                e.due = cyc + LAT;
                pend.push_back(e);
                pushed++;
            end
        end
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        compare();
        dropped += pend.size();
        pend.delete();
        hist.delete();
        idle_tag = "R1";
        rst_n = 1'b0;
        in_valid = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            compare();
        end
        rst_n = 1'b1;
    endtask

    function automatic int rnd_sample();
        logic signed [W-1:0] v = W'($urandom);
        return int'(v);
    endfunction

    initial begin
        do_reset(3);
        // R2: fill with a gap-free stream; no result until the LEN-th sample
        idle_tag = "R2";
        for (int k = 0; k < LEN - 1; k++) step(1'b1, rnd_sample());
        // R3: steady random stream
        for (int k = 0; k < 60; k++) step(1'b1, rnd_sample());
        // R5: random stalls, no result on idle cycles
        idle_tag = "R5";
        for (int k = 0; k < 100; k++) step(($urandom % 2) == 0, rnd_sample());
        // R6: full-scale inputs
        idle_tag = "R6";
        for (int k = 0; k < 20; k++) step(1'b1, -128);
        for (int k = 0; k < 20; k++) step(1'b1, 127);
        for (int k = 0; k < 20; k++) step(1'b1, (k % 2) ? 127 : -128);
        // R1: reset mid-stream, then refill with stalls (R2)
        do_reset(2);
        idle_tag = "R2";
        for (int k = 0; k < 40; k++) step(($urandom % 3) != 0, rnd_sample());
        idle_tag = "R7";
        for (int k = 0; k < LAT + 4; k++) step(1'b0, 0);
        // R7: every eligible sample produced exactly one result
        chk(pend.size() == 0, "R7", pend.size(), 0);
        chk(got == pushed - dropped, "R7", got, pushed - dropped);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule